// File: doc/BRIEF.md
# Single-Channel Cycle-Stealing DMA Engine

This block moves a programmed run of words between one I/O device port and memory. Software fills three registers: the first memory address, the number of words, and a control word. The control word holds the direction, the transfer mode and the device number, and its start bit launches the job. The engine then asks the bus controller for the bus and moves words only while it holds a grant. Each word is carried in a single bus cycle, directly from the device to memory or from memory to the device.

Two modes are offered. In block mode the request stays up from the first word to the last, so the processor is held off the bus for the whole job. In cycle-steal mode one word is taken in each granted cycle that the bus controller also marks as idle, and the request drops after every word to hand the bus back. When the count reaches zero the engine drops its request, sets a sticky done flag and pulses an interrupt.

Top module: `cs_dma_top`

## Requirements
- R1: Register writes use index 1 for the first memory address, index 2 for the word count, and index 0 for control. In the control word, bit 0 is start, bit 1 is direction, bit 2 is mode (0 block, 1 cycle-steal) and bits 8 and up hold the device number. A control write with bit 0 set starts a job.
- R2: A word moves (strobes high) only in a cycle where `bus_req` and `bus_grant` are both high.
- R3: In cycle-steal mode a word moves in every cycle with request, grant and `bus_idle` all high, never when `bus_idle` is low, and `bus_req` is low in the cycle after each word.
- R4: In block mode `bus_req` stays high from start until the last word, with one word moved in every granted cycle, so it falls exactly once per job.
- R5: Direction 0 reads the device and writes memory (`mem_we`=1, `mem_wdata`=`dev_rdata`). Direction 1 reads memory and writes the device (`dev_we`=1, `dev_wdata`=`mem_rdata`). `dev_addr` carries the programmed device number.
- R6: After the last word `bus_req` is low, `done` is high, and `irq` is high for exactly one cycle.
- R7: The memory address starts at the programmed value and rises by one per word, wrapping modulo 2^ADDR_W. Exactly the programmed count of words is moved.
- R8: A start with count zero sets `done` and pulses `irq` in the next cycle, and never raises `bus_req`.
- R9: Register writes of any index while `busy` is high have no effect on the running job or on later state.
- R10: A control write while idle clears `done`. A write with start clear leaves the engine idle.
- R11: After reset, `bus_req`, `done`, `irq` and `busy` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register index |
| reg_wdata | input | REG_W | Register write data |
| bus_req | output | 1 | Bus request to the bus controller |
| bus_grant | input | 1 | Bus grant from the bus controller |
| bus_idle | input | 1 | Bus otherwise unused this cycle |
| mem_addr | output | ADDR_W | Memory word address |
| mem_wdata | output | DATA_W | Data written to memory |
| mem_rdata | input | DATA_W | Data read from memory |
| mem_we | output | 1 | Memory write enable |
| mem_strobe | output | 1 | Memory access this cycle |
| dev_addr | output | DEV_W | Selected device number |
| dev_wdata | output | DATA_W | Data written to the device |
| dev_rdata | input | DATA_W | Data read from the device |
| dev_we | output | 1 | Device write enable |
| dev_strobe | output | 1 | Device access this cycle |
| busy | output | 1 | Job in progress |
| done | output | 1 | Sticky completion flag |
| irq | output | 1 | One-cycle completion interrupt |

## Verification
The bench builds the engine with ADDR_W=8, CNT_W=4, DEV_W=4 and DATA_W=16. The narrow address lets a job starting near the top of memory wrap through zero. The 4-bit count makes the largest job (15 words) short enough to run in full. A pseudo-random grant and idle pattern exercises both modes, including grant gaps in the middle of a block job. The same pattern sets whether a stolen cycle is accepted or refused.

// File: rtl/cs_dma_pkg.sv
// Package: shared encodings for the cycle-stealing DMA engine.
// Assumes: register indices and control-bit positions are a software contract.
package cs_dma_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_XFER = 2'd1,
        ST_GAP  = 2'd2
    } dma_state_t;

    localparam logic [1:0] RA_CTRL  = 2'd0;
    localparam logic [1:0] RA_BASE  = 2'd1;
    localparam logic [1:0] RA_COUNT = 2'd2;

    localparam int CTRL_START_BIT = 0;
    localparam int CTRL_DIR_BIT   = 1;
    localparam int CTRL_MODE_BIT  = 2;
    localparam int CTRL_DEV_LSB   = 8;
endpackage

// File: rtl/cs_dma_regs.sv
// Module: cs_dma_regs
// Holds the programmed job description and decodes start and control writes.
// Assumes: REG_W covers ADDR_W, CNT_W and CTRL_DEV_LSB+DEV_W bits. Every
// write is dropped while a job is busy.
module cs_dma_regs
    import cs_dma_pkg::*;
#(
    parameter int REG_W  = 32,
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 16,
    parameter int DEV_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [1:0]        reg_addr,
    input  logic [REG_W-1:0]  reg_wdata,
    input  logic              busy,
    output logic              cfg_dir,
    output logic              cfg_steal,
    output logic [DEV_W-1:0]  cfg_dev,
    output logic [ADDR_W-1:0] cfg_base,
    output logic [CNT_W-1:0]  cfg_count,
    output logic              start_pulse,
    output logic              ctrl_wr
);
    logic wr_ok;
    logic unused_wdata;

    assign unused_wdata = ^reg_wdata;
    assign wr_ok        = reg_we && !busy;
    assign ctrl_wr      = wr_ok && (reg_addr == RA_CTRL);
    assign start_pulse  = ctrl_wr && reg_wdata[CTRL_START_BIT];

    // Capture register writes accepted while idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_dir   <= 1'b0;
            cfg_steal <= 1'b0;
            cfg_dev   <= '0;
            cfg_base  <= '0;
            cfg_count <= '0;
        end else if (wr_ok) begin
            case (reg_addr)
                RA_CTRL: begin
                    cfg_dir   <= reg_wdata[CTRL_DIR_BIT];
                    cfg_steal <= reg_wdata[CTRL_MODE_BIT];
                    cfg_dev   <= reg_wdata[CTRL_DEV_LSB +: DEV_W];
                end
                RA_BASE:  cfg_base  <= reg_wdata[ADDR_W-1:0];
                RA_COUNT: cfg_count <= reg_wdata[CNT_W-1:0];
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/cs_dma_datapath.sv
// Module: cs_dma_datapath
// Running memory address and remaining-word counter, plus data steering.
// Assumes: load and step are never high together; the address wraps naturally.
module cs_dma_datapath #(
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 16,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              step,
    input  logic [ADDR_W-1:0] base,
    input  logic [CNT_W-1:0]  count,
    input  logic [DATA_W-1:0] dev_rdata,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [ADDR_W-1:0] cur_addr,
    output logic              count_zero,
    output logic              last_word,
    output logic [DATA_W-1:0] mem_wdata,
    output logic [DATA_W-1:0] dev_wdata
);
    localparam logic [CNT_W-1:0]  CNT_ONE  = CNT_W'(1);
    localparam logic [ADDR_W-1:0] ADDR_ONE = ADDR_W'(1);

    logic [CNT_W-1:0] remaining;

    assign count_zero = (count == '0);
    assign last_word  = (remaining == CNT_ONE);
    assign mem_wdata  = dev_rdata;
    assign dev_wdata  = mem_rdata;

    // Load the job on start, then advance address and count per moved word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_addr  <= '0;
            remaining <= '0;
        end else if (load) begin
            cur_addr  <= base;
            remaining <= count;
        end else if (step) begin
            cur_addr  <= cur_addr + ADDR_ONE;
            remaining <= remaining - CNT_ONE;
        end
    end
endmodule

// File: rtl/cs_dma_fsm.sv
// Module: cs_dma_fsm
// Bus ownership sequencing for block and cycle-steal modes, completion flags.
// Assumes: steal is stable while busy; a start is only seen while idle.
module cs_dma_fsm
    import cs_dma_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start_pulse,
    input  logic ctrl_wr,
    input  logic count_zero,
    input  logic last_word,
    input  logic steal,
    input  logic bus_grant,
    input  logic bus_idle,
    output logic move,
    output logic bus_req,
    output logic busy,
    output logic done,
    output logic irq
);
    dma_state_t state, state_nx;
    logic finish;

    assign bus_req = (state == ST_XFER);
    assign busy    = (state != ST_IDLE);
    assign move    = bus_req && bus_grant && (!steal || bus_idle);

    // Next-state selection and completion detection.
    always_comb begin
        state_nx = state;
        finish   = 1'b0;
        case (state)
            ST_IDLE: begin
                if (start_pulse) begin
                    if (count_zero) finish = 1'b1;
                    else            state_nx = ST_XFER;
                end
            end
            ST_XFER: begin
                if (move) begin
                    if (last_word) begin
                        state_nx = ST_IDLE;
                        finish   = 1'b1;
                    end else if (steal) begin
                        state_nx = ST_GAP;
                    end
                end
            end
            ST_GAP:  state_nx = ST_XFER;
            default: state_nx = ST_IDLE;
        endcase
    end

    // State register and sticky done / pulsed interrupt.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            done  <= 1'b0;
            irq   <= 1'b0;
        end else begin
            state <= state_nx;
            irq   <= finish;
            if (finish)       done <= 1'b1;
            else if (ctrl_wr) done <= 1'b0;
        end
    end
endmodule

// File: rtl/cs_dma_top.sv
// Module: cs_dma_top
// Single-channel DMA engine: device <-> memory, one word per bus cycle,
// block or cycle-steal ownership, completion interrupt.
// Assumes: memory and device reads return data combinationally in the strobe cycle.
module cs_dma_top #(
    parameter int REG_W  = 32,
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 16,
    parameter int DEV_W  = 4,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [1:0]        reg_addr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic              bus_req,
    input  logic              bus_grant,
    input  logic              bus_idle,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              mem_we,
    output logic              mem_strobe,
    output logic [DEV_W-1:0]  dev_addr,
    output logic [DATA_W-1:0] dev_wdata,
    input  logic [DATA_W-1:0] dev_rdata,
    output logic              dev_we,
    output logic              dev_strobe,
    output logic              busy,
    output logic              done,
    output logic              irq
);
    logic              cfg_dir;
    logic              cfg_steal;
    logic [DEV_W-1:0]  cfg_dev;
    logic [ADDR_W-1:0] cfg_base;
    logic [CNT_W-1:0]  cfg_count;
    logic              start_pulse;
    logic              ctrl_wr;
    logic              count_zero;
    logic              last_word;
    logic              move;

    cs_dma_regs #(
        .REG_W(REG_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W), .DEV_W(DEV_W)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .busy(busy), .cfg_dir(cfg_dir),
        .cfg_steal(cfg_steal), .cfg_dev(cfg_dev), .cfg_base(cfg_base),
        .cfg_count(cfg_count), .start_pulse(start_pulse), .ctrl_wr(ctrl_wr)
    );

    cs_dma_datapath #(
        .ADDR_W(ADDR_W), .CNT_W(CNT_W), .DATA_W(DATA_W)
    ) u_path (
        .clk(clk), .rst_n(rst_n), .load(start_pulse), .step(move),
        .base(cfg_base), .count(cfg_count), .dev_rdata(dev_rdata),
        .mem_rdata(mem_rdata), .cur_addr(mem_addr), .count_zero(count_zero),
        .last_word(last_word), .mem_wdata(mem_wdata), .dev_wdata(dev_wdata)
    );

    cs_dma_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .start_pulse(start_pulse), .ctrl_wr(ctrl_wr),
        .count_zero(count_zero), .last_word(last_word), .steal(cfg_steal),
        .bus_grant(bus_grant), .bus_idle(bus_idle), .move(move),
        .bus_req(bus_req), .busy(busy), .done(done), .irq(irq)
    );

    assign dev_addr   = cfg_dev;
    assign mem_strobe = move;
    assign dev_strobe = move;
    assign mem_we     = move && !cfg_dir;
    assign dev_we     = move && cfg_dir;
endmodule

// File: rtl/cs_dma_checker.sv
// Module: cs_dma_checker
// Protocol properties of the DMA engine, bound to cs_dma_top.
// Assumes: sampled on the rising clock edge, disabled during reset.
module cs_dma_checker (
    input logic clk,
    input logic rst_n,
    input logic bus_req,
    input logic bus_grant,
    input logic bus_idle,
    input logic mem_strobe,
    input logic mem_we,
    input logic dev_we,
    input logic irq,
    input logic done,
    input logic cfg_steal,
    input logic start_pulse,
    input logic count_zero
);
    assert_move_granted_R2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_strobe |-> (bus_req && bus_grant));

    assert_steal_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_strobe && cfg_steal) |-> bus_idle);

    assert_steal_release_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_strobe && cfg_steal) |=> !bus_req);

    assert_block_release_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(bus_req) && !cfg_steal) |-> irq);

    assert_dir_exclusive_R5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_strobe |-> (mem_we != dev_we));

    assert_irq_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);

    assert_irq_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (done && !bus_req));

    assert_zero_count_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (start_pulse && count_zero) |=> (irq && !bus_req));
endmodule

bind cs_dma_top cs_dma_checker u_chk (
    .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_grant(bus_grant),
    .bus_idle(bus_idle), .mem_strobe(mem_strobe), .mem_we(mem_we),
    .dev_we(dev_we), .irq(irq), .done(done), .cfg_steal(cfg_steal),
    .start_pulse(start_pulse), .count_zero(count_zero)
);

// File: tb/cs_dma_top_tb.sv
`timescale 1ns/1ps
module cs_dma_top_tb;
    localparam int REG_W  = 32;
    localparam int ADDR_W = 8;
    localparam int CNT_W  = 4;
    localparam int DEV_W  = 4;
    localparam int DATA_W = 16;

    typedef struct {
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
        logic [DEV_W-1:0]  dev;
        logic              to_mem;
    } item_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic reg_we = 1'b0;
    logic [1:0] reg_addr = '0;
    logic [REG_W-1:0] reg_wdata = '0;
    logic bus_req, bus_grant, bus_idle;
    logic [ADDR_W-1:0] mem_addr;
    logic [DATA_W-1:0] mem_wdata, mem_rdata, dev_wdata, dev_rdata;
    logic mem_we, mem_strobe, dev_we, dev_strobe, busy, done, irq;
    logic [DEV_W-1:0] dev_addr;

    int compared = 0;
    int mismatched = 0;
    bit finished = 0;
    item_t sb[$];
    int words = 0, irqs = 0, req_falls = 0;
    bit prev_req = 0;
    bit job_steal = 0;
    bit hold_grant = 0;
    logic [15:0] lfsr = 16'hACE1;
    logic [DATA_W-1:0] dev_cnt = '0;

    always #4 clk = ~clk;

    cs_dma_top #(.REG_W(REG_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W),
                 .DEV_W(DEV_W), .DATA_W(DATA_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .bus_req(bus_req), .bus_grant(bus_grant),
        .bus_idle(bus_idle), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .mem_we(mem_we), .mem_strobe(mem_strobe),
        .dev_addr(dev_addr), .dev_wdata(dev_wdata), .dev_rdata(dev_rdata),
        .dev_we(dev_we), .dev_strobe(dev_strobe), .busy(busy), .done(done),
        .irq(irq)
    );

    // Bench memory and device models
    assign mem_rdata = {{(DATA_W-ADDR_W){1'b0}}, mem_addr} ^ 16'hA5A5;
    assign dev_rdata = 16'h5000 + dev_cnt;
    assign bus_grant = bus_req && !hold_grant && lfsr[0];
    assign bus_idle  = lfsr[3];

    always @(posedge clk) begin
        lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        if (dev_strobe && !dev_we) dev_cnt <= dev_cnt + 1'b1;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        compared++;
        if (!ok) begin
            mismatched++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Monitor: pop expected items as words move, and watch bus behaviour
    always @(negedge clk) begin
        if (rst_n) begin
            if (mem_strobe) begin
                words++;
                if (sb.size() == 0) begin
                    check(0, "R7 unexpected word", int'(mem_addr), -1);
                end else begin
                    item_t e;
                    e = sb.pop_front();
                    check(mem_addr == e.addr, "R7 address", int'(mem_addr), int'(e.addr));
                    check(dev_addr == e.dev, "R5 device", int'(dev_addr), int'(e.dev));
                    if (e.to_mem)
                        check(mem_we && !dev_we && mem_wdata == e.data, "R5 to memory",
                              int'(mem_wdata), int'(e.data));
                    else
                        check(dev_we && !mem_we && dev_wdata == e.data, "R5 to device",
                              int'(dev_wdata), int'(e.data));
                end
                if (!(bus_req && bus_grant)) check(0, "R2 move without grant", 0, 1);
                if (job_steal && !bus_idle) check(0, "R3 move on busy bus", 0, 1);
            end else if (bus_req && bus_grant && !hold_grant) begin
                if (!job_steal) check(0, "R4 granted cycle unused", 0, 1);
                else if (bus_idle) check(0, "R3 idle slot unused", 0, 1);
            end
            if (irq) irqs++;
            if (prev_req && !bus_req) req_falls++;
            prev_req = bus_req;
        end
    end

    task automatic wr(input logic [1:0] a, input logic [REG_W-1:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    function automatic logic [REG_W-1:0] ctrl(input bit start, input bit dir,
                                              input bit steal, input int dev);
        return REG_W'(start) | (REG_W'(dir) << 1) | (REG_W'(steal) << 2) |
               (REG_W'(dev & 4'hF) << 8);
    endfunction

    task automatic wait_done(input string req);
        bit seen = 0;
        for (int k = 0; k < 4000; k++) begin
            @(negedge clk);
            if (done) begin seen = 1; break; end
        end
        check(seen, req, int'(done), 1);
    endtask

    // Driver: push expected items, program and start, then check completion
    task automatic run_job(input bit dir, input bit steal, input int dev,
                           input int base, input int cnt, input bit busy_writes);
        @(negedge clk);
        words = 0; irqs = 0; req_falls = 0; dev_cnt = '0; job_steal = steal;
        for (int i = 0; i < cnt; i++) begin
            item_t e;
            e.addr   = ADDR_W'(base + i);
            e.dev    = DEV_W'(dev);
            e.to_mem = !dir;
            e.data   = dir ? ({{(DATA_W-ADDR_W){1'b0}}, e.addr} ^ 16'hA5A5)
                           : (16'h5000 + DATA_W'(i));
            sb.push_back(e);
        end
        wr(2'd1, REG_W'(base));
        wr(2'd2, REG_W'(cnt));
        if (busy_writes) hold_grant = 1;
        wr(2'd0, ctrl(1, dir, steal, dev));
        if (busy_writes) begin
            // R9: all of these land while busy and must change nothing
            wr(2'd1, REG_W'(8'h77));
            wr(2'd2, REG_W'(3));
            wr(2'd0, ctrl(1, !dir, !steal, dev + 1));
            check(busy && !done, "R9 still running", int'(busy), 1);
            hold_grant = 0;
        end
        wait_done(cnt == 0 ? "R8 done" : "R6 done");
        repeat (3) @(negedge clk);
        check(irqs == 1, "R6 one irq cycle", irqs, 1);
        check(words == cnt, "R7 word count", words, cnt);
        check(sb.size() == 0, "R7 all words", sb.size(), 0);
        check(!bus_req && !busy, "R6 bus released", int'(bus_req), 0);
        if (cnt == 0)
            check(req_falls == 0, "R8 no request", req_falls, 0);
        else if (steal)
            check(req_falls == cnt, "R3 release per word", req_falls, cnt);
        else
            check(req_falls == 1, "R4 single hold", req_falls, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(!bus_req && !done && !irq && !busy, "R11 reset state",
              {bus_req, done, irq, busy}, 0);
        run_job(0, 0, 3, 8'h10, 5, 0);    // R1 R4 R5 block, device to memory
        run_job(1, 1, 9, 8'hFC, 7, 0);    // R3 R7 steal, memory to device, wraps
        run_job(0, 1, 5, 8'h40, 15, 0);   // R3 largest count
        run_job(1, 0, 2, 8'h80, 1, 0);    // R4 single word
        run_job(0, 0, 1, 8'h20, 0, 0);    // R8 zero count
        run_job(1, 0, 6, 8'h30, 4, 1);    // R9 writes while busy
        check(done, "R10 done held", int'(done), 1);
        wr(2'd0, ctrl(0, 0, 0, 0));
        @(negedge clk);
        check(!done && !busy && !bus_req, "R10 done cleared, idle",
              {done, busy, bus_req}, 0);
        repeat (4) @(negedge clk);
        check(!irq && !bus_req, "R10 no restart", {irq, bus_req}, 0);
        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            compared++;
            mismatched++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end
endmodule